// File: doc/BRIEF.md
# Shared-Memory Access Bridge

This block gives a small processor a byte-wide register window onto a large 32-bit word memory that a second master also uses. Software first raises an ownership request in the control register. It then waits until the grant flag reads 1. After that it launches single-word transfers. Each transfer either writes the four byte-wide data registers into the memory location named by a 24-bit address or reads that location back into them.

Each write carries byte enables. After each completed transfer the address moves on by a programmable step. The other master keeps fixed priority whenever ownership has not been granted. The grant is only given in a cycle when that master is idle. Once given, the grant holds until software clears its request.

Toward the memory the bridge has a valid/ready request channel. The bridge raises `mem_valid` and holds the request fields steady until the memory answers with `mem_ready`, so the memory can apply back-pressure for any number of cycles. Read data comes back on a later cycle, flagged by a single-cycle `mem_rvalid` pulse. There is no back-pressure on the return path, so the bridge must accept read data in the cycle it arrives.

Top module: `sm_bridge`

## Requirements
- R1: The grant (`bridge_grant`, control bit 4) rises only in the cycle after one in which the request (control bit 7) was set and `peer_busy` was low. It then stays high while the request stays set, whatever `peer_busy` does. It drops in the cycle after the request is cleared.
- R2: After reset every register reads 0, `bridge_grant` is 0 and `mem_valid` is 0.
- R3: If the start bit (control bit 6) is written as 1 while the grant is low, no memory request is made, the address is unchanged, and the start bit reads 0 one cycle after the write.
- R4: On a write transfer (control bit 5 = 0), one request is issued with `mem_write`=1, `mem_addr` equal to the address registers, and `mem_wdata` = {DATA3,DATA2,DATA1,DATA0}, where DATA3 is bits 31:24. `mem_be` equals control bits 3..0, bit n guarding byte n. Only the enabled bytes of the word change.
- R5: On a read transfer (control bit 5 = 1), the returned word is loaded into all four data registers, with bits 31:24 going to DATA3 and bits 7:0 going to DATA0.
- R6: After each transfer the 24-bit address becomes the old address plus the 8-bit step register, wrapping modulo 2^24.
- R7: The start bit reads 1 for the whole transfer. With a memory that is ready at once, it clears 3 cycles after the start write for a write and 4 cycles after it for a read.
- R8: The register offsets are: 0 control, 1 step, 2/3/4 address bits 23:16/15:8/7:0, and 5/6/7/8 DATA3..DATA0. The control register reads {request, start, direction, grant, enables[3:0]}. The grant bit ignores writes.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_wdata` hold. Each cycle of stall adds one cycle to the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| peer_busy | input | 1 | Other master is using the memory this cycle |
| bridge_grant | output | 1 | Ownership granted; other master must hold off |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_be | output | 4 | Byte enables, bit n for bits 8n+7:8n |
| mem_addr | output | 24 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid (one cycle) |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest cases to reach are a start issued with no grant and a request that stalls under back-pressure. Both need the arbitration input and the memory's ready line to be in a particular state at the moment the control write lands.

The bench covers them in three ways. It drops the request before starting, so the grant is low when the start bit arrives. It forces `mem_ready` low for a counted stretch while a write is pending. It toggles `peer_busy` on both sides of the grant edge. Transfer lengths are measured by polling the start bit once per cycle.

// File: rtl/sm_bridge_pkg.sv
package sm_bridge_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ISSUE, SEQ_WAIT, SEQ_DONE} seq_state_e;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned CTRL_REQ  = 7;
  localparam int unsigned CTRL_GO   = 6;
  localparam int unsigned CTRL_DIR  = 5;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_STEP  = 1;
  localparam int unsigned IDX_ADDR  = 2;
endpackage

// File: rtl/sm_bridge_arb.sv
module sm_bridge_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic peer_busy,
  output logic grant
);
  always_ff @(posedge clk) begin
    if (!rst_n)          grant <= 1'b0;
    else if (!req)       grant <= 1'b0;
    else if (!peer_busy) grant <= 1'b1;
  end
endmodule

// File: rtl/sm_bridge_seq.sv
module sm_bridge_seq
  import sm_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic grant,
  input  logic dir_rd,
  input  logic mem_ready,
  input  logic mem_rvalid,
  output logic mem_valid,
  output logic mem_write,
  output logic advance,
  output logic latch,
  output logic clear_go,
  output logic idle
);
  seq_state_e state_q, state_d;
  logic       rd_q;

  always_comb begin
    state_d   = state_q;
    mem_valid = 1'b0;
    advance   = 1'b0;
    latch     = 1'b0;
    clear_go  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (go) begin
          if (grant) state_d = SEQ_ISSUE;
          else       clear_go = 1'b1;
        end
      end
      SEQ_ISSUE: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          if (rd_q) state_d = SEQ_WAIT;
          else begin
            advance = 1'b1;
            state_d = SEQ_DONE;
          end
        end
      end
      SEQ_WAIT: begin
        if (mem_rvalid) begin
          latch   = 1'b1;
          advance = 1'b1;
          state_d = SEQ_DONE;
        end
      end
      SEQ_DONE: begin
        clear_go = 1'b1;
        state_d  = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && go && grant) rd_q <= dir_rd;
    end
  end

  assign mem_write = !rd_q;
  assign idle      = (state_q == SEQ_IDLE);
endmodule

// File: rtl/sm_bridge.sv
module sm_bridge
  import sm_bridge_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 3,
  parameter int unsigned REG_AW     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [REG_AW-1:0]           reg_addr,
  input  logic [7:0]                  reg_wdata,
  output logic [7:0]                  reg_rdata,
  input  logic                        peer_busy,
  output logic                        bridge_grant,
  output logic                        mem_valid,
  input  logic                        mem_ready,
  output logic                        mem_write,
  output logic [NUM_LANES-1:0]        mem_be,
  output logic [8*ADDR_BYTES-1:0]     mem_addr,
  output logic [8*NUM_LANES-1:0]      mem_wdata,
  input  logic                        mem_rvalid,
  input  logic [8*NUM_LANES-1:0]      mem_rdata
);
  localparam int unsigned ADDR_W   = 8 * ADDR_BYTES;
  localparam int unsigned DATA_W   = 8 * NUM_LANES;
  localparam int unsigned IDX_DATA = IDX_ADDR + ADDR_BYTES;

  logic                 req_q, go_q, dir_q;
  logic [NUM_LANES-1:0] be_q;
  logic [7:0]           step_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    data_q;
  logic                 advance, latch, clear_go, seq_idle;
  logic                 ctrl_wr;

  assign ctrl_wr = reg_we && (reg_addr == REG_AW'(IDX_CTRL));

  sm_bridge_arb arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_q),
    .peer_busy (peer_busy),
    .grant     (bridge_grant)
  );

  sm_bridge_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go_q),
    .grant      (bridge_grant),
    .dir_rd     (dir_q),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .advance    (advance),
    .latch      (latch),
    .clear_go   (clear_go),
    .idle       (seq_idle)
  );

  // control and step registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      be_q   <= '0;
      step_q <= '0;
    end else begin
      if (ctrl_wr) begin
        req_q <= reg_wdata[CTRL_REQ];
        dir_q <= reg_wdata[CTRL_DIR];
        be_q  <= reg_wdata[NUM_LANES-1:0];
      end
      if (clear_go)                          go_q <= 1'b0;
      else if (ctrl_wr && reg_wdata[CTRL_GO]) go_q <= 1'b1;
      if (reg_we && reg_addr == REG_AW'(IDX_STEP)) step_q <= reg_wdata;
    end
  end

  // address registers: sequencer update wins over a software write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (advance) begin
      addr_q <= addr_q + {{(ADDR_W-8){1'b0}}, step_q};
    end else begin
      for (int i = 0; i < ADDR_BYTES; i++) begin
        if (reg_we && reg_addr == REG_AW'(IDX_ADDR + i))
          addr_q[(ADDR_BYTES-1-i)*8 +: 8] <= reg_wdata;
      end
    end
  end

  // data registers: offset IDX_DATA holds the most significant lane
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (latch) begin
      data_q <= mem_rdata;
    end else begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (reg_we && reg_addr == REG_AW'(IDX_DATA + i))
          data_q[(NUM_LANES-1-i)*8 +: 8] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == REG_AW'(IDX_CTRL))
      reg_rdata = {req_q, go_q, dir_q, bridge_grant, be_q};
    if (reg_addr == REG_AW'(IDX_STEP))
      reg_rdata = step_q;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (reg_addr == REG_AW'(IDX_ADDR + i))
        reg_rdata = addr_q[(ADDR_BYTES-1-i)*8 +: 8];
    for (int i = 0; i < NUM_LANES; i++)
      if (reg_addr == REG_AW'(IDX_DATA + i))
        reg_rdata = data_q[(NUM_LANES-1-i)*8 +: 8];
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_be    = be_q;
endmodule

// File: rtl/sm_bridge_chk.sv
module sm_bridge_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              go,
  input logic              grant,
  input logic              idle,
  input logic              peer_busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [7:0]        step
);
  AST_GRANT_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req && !peer_busy)); // R1
  AST_GRANT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req) |=> grant); // R1
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !grant); // R1
  AST_NO_UNGRANTED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> grant); // R3
  AST_ABORT_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && go && !grant) |=> !go); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_write) |=> mem_addr == ($past(mem_addr) + ADDR_W'($past(step)))); // R6
  AST_START_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> go); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata))); // R9
endmodule

bind sm_bridge sm_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req_q),
  .go        (go_q),
  .grant     (bridge_grant),
  .idle      (seq_idle),
  .peer_busy (peer_busy),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .step      (step_q)
);

// File: tb/sm_bridge_tb_top.sv
module sm_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        peer_busy = 1'b0;
  logic        bridge_grant;
  logic        mem_valid, mem_write, mem_rvalid;
  logic        ram_stall = 1'b0;
  logic        mem_ready;
  logic [3:0]  mem_be;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;
  int accepts = 0;
  logic [23:0] last_addr;
  logic [31:0] last_wdata;
  logic [3:0]  last_be;
  logic        last_write;

  logic [31:0] ram   [256];
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  assign mem_ready = !ram_stall;

  sm_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .peer_busy(peer_busy),
    .bridge_grant(bridge_grant), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_be(mem_be), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // simple synchronous RAM, one-cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else if (mem_valid && mem_ready) begin
      accepts    <= accepts + 1;
      last_addr  <= mem_addr;
      last_wdata <= mem_wdata;
      last_be    <= mem_be;
      last_write <= mem_write;
      if (mem_write) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) ram[mem_addr[7:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
        mem_rvalid <= 1'b0;
      end else begin
        mem_rdata  <= ram[mem_addr[7:0]];
        mem_rvalid <= 1'b1;
      end
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  // {be[3:0], addr[23:0], step[7:0], data[31:0]}
  localparam logic [67:0] VEC [4] = '{
    {4'hF, 24'h000010, 8'h01, 32'h11223344},
    {4'h5, 24'h000010, 8'h04, 32'hAABBCCDD},
    {4'h0, 24'h000020, 8'h00, 32'hDEADBEEF},
    {4'hA, 24'hFFFFFE, 8'h05, 32'h0F1E2D3C}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(idx); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [7:0] v);
    reg_addr = 4'(idx);
    #0.5;
    v = reg_rdata;
  endtask

  task automatic rd_addr(output logic [23:0] a);
    logic [7:0] b2, b1, b0;
    rd(2, b2); rd(3, b1); rd(4, b0);
    a = {b2, b1, b0};
  endtask

  task automatic set_addr(input logic [23:0] a);
    wr(2, a[23:16]); wr(3, a[15:8]); wr(4, a[7:0]);
  endtask

  // write control, then count cycles until start bit reads 0
  task automatic xfer(input logic [7:0] cv, output int n);
    logic [7:0] c;
    wr(0, cv);
    n = 0;
    rd(0, c);
    while (c[6] && n < 50) begin
      @(negedge clk);
      n++;
      rd(0, c);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = d[k*8 +: 8];
    return r;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0]  v;
    logic [23:0] a;
    logic [31:0] w;
    int n, acc0;
    for (int i = 0; i < 256; i++) begin
      ram[i]   = {8'h5A, 8'(i), ~8'(i), 8'hC3};
      model[i] = {8'h5A, 8'(i), ~8'(i), 8'hC3};
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    for (int i = 0; i < 9; i++) begin
      rd(i, v);
      check(v == 8'h00, "R2 register reset", 32'(v), 32'h0);
    end
    check(!bridge_grant && !mem_valid, "R2 outputs idle", {30'b0, bridge_grant, mem_valid}, 32'h0);

    // R3: start without grant
    set_addr(24'h000040);
    wr(1, 8'h01);
    acc0 = accepts;
    xfer(8'h4F, n);
    check(n == 1, "R3 start clears in one cycle", 32'(n), 32'd1);
    check(accepts == acc0, "R3 no memory access", 32'(accepts), 32'(acc0));
    rd_addr(a);
    check(a == 24'h000040, "R3 address unchanged", 32'(a), 32'h40);

    // R1: grant held off by the other master
    peer_busy = 1'b1;
    wr(0, 8'h80);
    repeat (3) @(negedge clk);
    rd(0, v);
    check(v == 8'h80, "R1 no grant while peer busy", 32'(v), 32'h80);
    peer_busy = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(0, v);
    check(v == 8'h90, "R1 grant after peer idle", 32'(v), 32'h90);
    peer_busy = 1'b1;
    repeat (2) @(negedge clk);
    check(bridge_grant, "R1 grant sticky", 32'(bridge_grant), 32'h1);
    peer_busy = 1'b0;

    // R8: grant bit not writable, control layout
    wr(0, 8'hAA);
    rd(0, v);
    check(v == 8'hBA, "R8 control readback", 32'(v), 32'hBA);

    // vector table: write then read back
    for (int i = 0; i < 4; i++) begin
      logic [3:0]  be;
      logic [23:0] va;
      logic [7:0]  st;
      logic [31:0] dv;
      {be, va, st, dv} = VEC[i];
      set_addr(va);
      wr(1, st);
      wr(5, dv[31:24]); wr(6, dv[23:16]); wr(7, dv[15:8]); wr(8, dv[7:0]);
      acc0 = accepts;
      xfer({4'hC, be}, n);
      model[va[7:0]] = merge(model[va[7:0]], dv, be);
      check(n == 3, "R7 write length", 32'(n), 32'd3);
      check(accepts == acc0 + 1 && last_write && last_addr == va, "R4 write request", {8'b0, last_addr}, {8'b0, va});
      check(last_wdata == dv && last_be == be, "R4 write data and enables", last_wdata, dv);
      check(ram[va[7:0]] == model[va[7:0]], "R4 byte enables", ram[va[7:0]], model[va[7:0]]);
      rd_addr(a);
      check(a == va + 24'(st), "R6 address step after write", 32'(a), 32'(va + 24'(st)));

      set_addr(va);
      for (int k = 5; k < 9; k++) wr(k, 8'h00);
      xfer({4'hE, be}, n);
      check(n == 4, "R7 read length", 32'(n), 32'd4);
      rd(5, w[31:24]); rd(6, w[23:16]); rd(7, w[15:8]); rd(8, w[7:0]);
      check(w == model[va[7:0]], "R5 read data lanes", w, model[va[7:0]]);
      rd_addr(a);
      check(a == va + 24'(st), "R6 address step after read", 32'(a), 32'(va + 24'(st)));
    end

    // R9: back-pressure adds cycles, request held
    set_addr(24'h000030);
    wr(1, 8'h02);
    wr(5, 8'h01); wr(6, 8'h02); wr(7, 8'h03); wr(8, 8'h04);
    ram_stall = 1'b1;
    fork
      xfer(8'hCF, n);
      begin repeat (4) @(negedge clk); ram_stall = 1'b0; end
    join
    check(n == 4, "R9 stalled write length", 32'(n), 32'd4);
    check(ram[8'h30] == 32'h01020304, "R9 stalled write data", ram[8'h30], 32'h01020304);
    rd_addr(a);
    check(a == 24'h000032, "R6 step after stalled write", 32'(a), 32'h32);

    // R1: release ownership
    wr(0, 8'h00);
    @(negedge clk);
    check(!bridge_grant, "R1 grant dropped on release", 32'(bridge_grant), 32'h0);

    finish_run();
  end
endmodule